// File: doc/BRIEF.md
# Integer shift and rotate unit

A 32-bit shift unit for an integer pipeline. It takes the decoded instruction fields: the function code, the 5-bit rs field, the 5-bit sa field, the rs register value and the rt register value. It produces the destination word and a reserved-instruction flag. It covers four kinds of operation: left shift, logical right shift, arithmetic right shift and rotate right. Each kind has an immediate form, whose amount comes from the sa field, and a register form, whose amount comes from the low bits of the rs value.

The unit checks every field that must be zero for the selected form. Any violation, and any function code outside the shift group, raises the illegal flag and forces the result to zero. Register access, hazards and exception delivery belong to the surrounding pipeline. A single output register captures the result whenever the input is valid, and `out_valid` follows `in_valid` by one clock.

Top module: `shift_unit`

## Requirements
- R1: Function code 0x00 shifts rt left by the sa field, filling with zeros. It is legal only when the rs field is zero.
- R2: Function code 0x02 shifts rt logically right by sa when rs field bit 0 is 0. It rotates rt right by sa when that bit is 1. Any non-zero value in rs field bits 4:1 makes the encoding illegal.
- R3: Function code 0x03 shifts rt arithmetically right by sa, filling vacated upper bits with copies of rt bit 31. It is legal only when the rs field is zero.
- R4: The register forms take their amount from rs value bits 4:0 only, and the upper rs bits have no effect. They are function code 0x04 (left shift), 0x06 (right shift) and 0x07 (arithmetic right shift). For code 0x06, sa field bit 0 selects rotate (1) or logical shift (0), and non-zero sa bits 4:1 are illegal. Codes 0x04 and 0x07 require the sa field to be zero.
- R5: An amount of 0 returns rt unchanged for every operation, including rotate.
- R6: Every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 is illegal.
- R7: An illegal encoding gives out_illegal = 1 and out_result = 0 in the output cycle of that input.
- R8: A valid input appears on the outputs after the next rising clock edge, with out_valid = 1 for that cycle. After a cycle with in_valid = 0, out_valid and out_illegal are 0 and out_result keeps its previous value.
- R9: While reset is asserted, out_valid, out_illegal and out_result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_funct | input | 6 | Function code of the instruction |
| in_rs_field | input | 5 | rs field of the instruction word |
| in_sa_field | input | 5 | sa field of the instruction word |
| in_rs_val | input | DATA_W | rs register value (register-form amount) |
| in_rt_val | input | DATA_W | rt register value (operand) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | DATA_W | Shifted or rotated word, zero when illegal |
| out_illegal | output | 1 | Reserved-instruction flag |

## Verification
The bench drives both rotate selectors: rs field bit 0 for the immediate form and sa field bit 0 for the register form. A decoder that mixed them up would return a logical shift where a rotate was expected. It applies an amount of zero to rotate and to arithmetic shift, where a design that computed a 32-bit complementary shift would corrupt rt. It also applies amounts of 31 with negative operands, which expose a missing sign fill. It sets each reserved bit on its own to catch a decoder that checks too few bits. Register amounts with junk in the upper rs bits catch a shifter that reads the full rs value. Idle cycles with changing inputs catch an output register that updates without in_valid.

// File: rtl/shift_pkg.sv
package shift_pkg;
   localparam int FUNCT_W = 6;
   localparam int FIELD_W = 5;

   localparam logic [FUNCT_W-1:0] FN_SLL_I = 6'h00;
   localparam logic [FUNCT_W-1:0] FN_SRX_I = 6'h02;
   localparam logic [FUNCT_W-1:0] FN_SRA_I = 6'h03;
   localparam logic [FUNCT_W-1:0] FN_SLL_R = 6'h04;
   localparam logic [FUNCT_W-1:0] FN_SRX_R = 6'h06;
   localparam logic [FUNCT_W-1:0] FN_SRA_R = 6'h07;

   typedef enum logic [1:0] {
      SH_SLL = 2'd0,
      SH_SRL = 2'd1,
      SH_SRA = 2'd2,
      SH_ROR = 2'd3
   } shop_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [shift_pkg::FUNCT_W-1:0] funct,
   input  logic [shift_pkg::FIELD_W-1:0] rs_field,
   input  logic [shift_pkg::FIELD_W-1:0] sa_field,
   input  logic [DATA_W-1:0]             rs_val,
   output shift_pkg::shop_e              op,
   output logic [AMT_W-1:0]              amt,
   output logic                          illegal
);
   import shift_pkg::*;

   logic use_reg_amt;
   logic unused_rs_hi;

   assign unused_rs_hi = ^rs_val[DATA_W-1:AMT_W];

   always_comb begin
      op          = SH_SLL;
      use_reg_amt = 1'b0;
      illegal     = 1'b0;
      unique case (funct)
         FN_SLL_I: begin
            illegal = (rs_field != '0);
         end
         FN_SRX_I: begin
            illegal = (rs_field[FIELD_W-1:1] != '0);
            op      = rs_field[0] ? SH_ROR : SH_SRL;
         end
         FN_SRA_I: begin
            illegal = (rs_field != '0);
            op      = SH_SRA;
         end
         FN_SLL_R: begin
            use_reg_amt = 1'b1;
            illegal     = (sa_field != '0);
         end
         FN_SRX_R: begin
            use_reg_amt = 1'b1;
            illegal     = (sa_field[FIELD_W-1:1] != '0);
            op          = sa_field[0] ? SH_ROR : SH_SRL;
         end
         FN_SRA_R: begin
            use_reg_amt = 1'b1;
            illegal     = (sa_field != '0);
            op          = SH_SRA;
         end
         default: illegal = 1'b1;
      endcase
   end

   assign amt = use_reg_amt ? rs_val[AMT_W-1:0] : sa_field[AMT_W-1:0];
endmodule

// File: rtl/shift_core.sv
module shift_core #(
   parameter int DATA_W     = 32,
   parameter bit USE_BARREL = 1'b1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  shift_pkg::shop_e  op,
   input  logic [AMT_W-1:0]  amt,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] result
);
   import shift_pkg::*;

   generate
      if (USE_BARREL) begin : g_barrel
         logic [DATA_W-1:0] data_rev;
         logic [DATA_W-1:0] st [0:AMT_W];
         logic [DATA_W-1:0] out_rev;
         logic              left;
         logic              rot;
         logic              fill;

         assign left = (op == SH_SLL);
         assign rot  = (op == SH_ROR);
         assign fill = (op == SH_SRA) & data[DATA_W-1];

         for (genvar b = 0; b < DATA_W; b++) begin : g_rev
            assign data_rev[b] = data[DATA_W-1-b];
            assign out_rev[b]  = st[AMT_W][DATA_W-1-b];
         end

         assign st[0] = left ? data_rev : data;

         for (genvar i = 0; i < AMT_W; i++) begin : g_stage
            localparam int S = 1 << i;
            logic [DATA_W-1:0] moved;
            assign moved = rot ? {st[i][S-1:0], st[i][DATA_W-1:S]}
                               : {{S{fill}}, st[i][DATA_W-1:S]};
            assign st[i+1] = amt[i] ? moved : st[i];
         end

         assign result = left ? out_rev : st[AMT_W];
      end else begin : g_behav
         logic [AMT_W:0] back;
         assign back = (AMT_W+1)'(DATA_W) - {1'b0, amt};
         always_comb begin
            unique case (op)
               SH_SLL:  result = data << amt;
               SH_SRL:  result = data >> amt;
               SH_SRA:  result = $unsigned($signed(data) >>> amt);
               default: result = (amt == '0) ? data
                                  : ((data >> amt) | (data << back));
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
   parameter int DATA_W     = 32,
   parameter bit USE_BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        in_funct,
   input  logic [4:0]        in_rs_field,
   input  logic [4:0]        in_sa_field,
   input  logic [DATA_W-1:0] in_rs_val,
   input  logic [DATA_W-1:0] in_rt_val,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_illegal
);
   import shift_pkg::*;

   localparam int AMT_W = $clog2(DATA_W);

   generate
      if ((DATA_W < 2) || ((1 << AMT_W) != DATA_W)) begin : g_bad_width
         $error("shift_unit: DATA_W must be a power of two, at least 2");
      end
      if (AMT_W > FIELD_W) begin : g_bad_amt
         $error("shift_unit: DATA_W too wide for the 5-bit amount field");
      end
   endgenerate

   shop_e             dec_op;
   logic [AMT_W-1:0]  dec_amt;
   logic              dec_illegal;
   logic [DATA_W-1:0] core_res;

   shift_decode #(.DATA_W(DATA_W)) decode_i (
      .funct    (in_funct),
      .rs_field (in_rs_field),
      .sa_field (in_sa_field),
      .rs_val   (in_rs_val),
      .op       (dec_op),
      .amt      (dec_amt),
      .illegal  (dec_illegal)
   );

   shift_core #(.DATA_W(DATA_W), .USE_BARREL(USE_BARREL)) core_i (
      .op     (dec_op),
      .amt    (dec_amt),
      .data   (in_rt_val),
      .result (core_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & dec_illegal;
         if (in_valid) begin
            out_result <= dec_illegal ? '0 : core_res;
         end
      end
   end

   // R7: a flagged result is always zero and always marked valid
   a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_valid && (out_result == '0)));

   // R8: output valid tracks input valid one cycle later
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));

   // R5: zero amount passes the operand through
   a_r5_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_illegal && (dec_amt == '0)) |=>
         (out_result == $past(in_rt_val)));

   // R2: rotation keeps the number of set bits
   a_r2_rotate_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_illegal && (dec_op == SH_ROR)) |=>
         ($countones(out_result) == $countones($past(in_rt_val))));

   // R3: negative operand keeps its sign under arithmetic shift
   a_r3_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_illegal && (dec_op == SH_SRA) && in_rt_val[DATA_W-1])
         |=> out_result[DATA_W-1]);
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  in_funct = '0;
   logic [4:0]  in_rs_field = '0;
   logic [4:0]  in_sa_field = '0;
   logic [31:0] in_rs_val = '0;
   logic [31:0] in_rt_val = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_illegal;

   int checks = 0;
   int fails  = 0;
   bit mon_en = 1'b0;
   logic [31:0] last_res = '0;
   logic [31:0] lfsr = 32'hACE1_2468;

   logic [31:0] q_res[$];
   logic        q_ill[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   shift_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_funct(in_funct),
      .in_rs_field(in_rs_field), .in_sa_field(in_sa_field),
      .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .out_valid(out_valid),
      .out_result(out_result), .out_illegal(out_illegal)
   );

   function automatic logic [32:0] model(input logic [5:0] f, input logic [4:0] rsf,
                                         input logic [4:0] saf, input logic [31:0] rsv,
                                         input logic [31:0] rtv);
      logic [4:0] a;
      logic       ill;
      logic [31:0] r;
      ill = 1'b0; r = '0;
      case (f)
         6'h00: begin ill = (rsf != 0); r = rtv << saf; end
         6'h02: begin
            ill = (rsf[4:1] != 0);
            if (rsf[0]) r = (saf == 0) ? rtv : ((rtv >> saf) | (rtv << (32 - saf)));
            else        r = rtv >> saf;
         end
         6'h03: begin ill = (rsf != 0); r = $unsigned($signed(rtv) >>> saf); end
         6'h04: begin ill = (saf != 0); a = rsv[4:0]; r = rtv << a; end
         6'h06: begin
            ill = (saf[4:1] != 0); a = rsv[4:0];
            if (saf[0]) r = (a == 0) ? rtv : ((rtv >> a) | (rtv << (32 - a)));
            else        r = rtv >> a;
         end
         6'h07: begin ill = (saf != 0); a = rsv[4:0]; r = $unsigned($signed(rtv) >>> a); end
         default: ill = 1'b1;
      endcase
      if (ill) r = '0;
      return {ill, r};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [5:0] f, input logic [4:0] rsf, input logic [4:0] saf,
                       input logic [31:0] rsv, input logic [31:0] rtv, input string tag);
      logic [32:0] m;
      @(negedge clk);
      in_valid = 1'b1; in_funct = f; in_rs_field = rsf; in_sa_field = saf;
      in_rs_val = rsv; in_rt_val = rtv;
      m = model(f, rsf, saf, rsv, rtv);
      q_res.push_back(m[31:0]);
      q_ill.push_back(m[32]);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         in_valid = 1'b0; in_funct = lfsr[5:0]; in_rs_field = lfsr[10:6];
         in_sa_field = lfsr[15:11]; in_rs_val = ~lfsr; in_rt_val = lfsr;
      end
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (mon_en) begin
         if (out_valid) begin
            if (q_res.size() == 0) begin
               check(1'b0, "R8 unexpected output", out_result, 32'h0);
            end else begin
               logic [31:0] er;
               logic        ei;
               string       et;
               er = q_res.pop_front(); ei = q_ill.pop_front(); et = q_tag.pop_front();
               check(out_result === er, et, out_result, er);
               check(out_illegal === ei, {et, " illegal flag"},
                     {31'h0, out_illegal}, {31'h0, ei});
            end
            last_res = out_result;
         end else begin
            check(out_illegal === 1'b0, "R8 flag while idle", {31'h0, out_illegal}, 32'h0);
            check(out_result === last_res, "R8 hold while idle", out_result, last_res);
         end
      end
   end

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R9 valid in reset", {31'h0, out_valid}, 32'h0);
      check(out_illegal === 1'b0, "R9 illegal in reset", {31'h0, out_illegal}, 32'h0);
      check(out_result === 32'h0, "R9 result in reset", out_result, 32'h0);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // R1 immediate left shift
      send(6'h00, 5'd0, 5'd4,  32'h0, 32'h8000_0001, "R1 sll 4");
      send(6'h00, 5'd0, 5'd31, 32'h0, 32'h0000_0003, "R1 sll 31");
      send(6'h00, 5'd1, 5'd4,  32'h0, 32'h1234_5678, "R1 rs field set");
      // R2 logical right / rotate split
      send(6'h02, 5'd0, 5'd4,  32'h0, 32'hF000_0000, "R2 srl 4");
      send(6'h02, 5'd1, 5'd8,  32'h0, 32'h1234_5678, "R2 rotr 8");
      send(6'h02, 5'd1, 5'd31, 32'h0, 32'h8000_0001, "R2 rotr 31");
      send(6'h02, 5'd2, 5'd4,  32'h0, 32'h1234_5678, "R2 reserved bit1");
      send(6'h02, 5'd16, 5'd4, 32'h0, 32'h1234_5678, "R2 reserved bit4");
      send(6'h02, 5'd17, 5'd4, 32'h0, 32'h1234_5678, "R2 reserved with rotate");
      idle(2);
      // R3 arithmetic right
      send(6'h03, 5'd0, 5'd31, 32'h0, 32'h8000_0000, "R3 sra neg 31");
      send(6'h03, 5'd0, 5'd4,  32'h0, 32'h7FFF_FFFF, "R3 sra pos 4");
      send(6'h03, 5'd0, 5'd8,  32'h0, 32'h8123_4567, "R3 sra neg 8");
      send(6'h03, 5'd4, 5'd1,  32'h0, 32'h8000_0000, "R3 rs field set");
      // R4 register forms, junk in upper rs bits
      send(6'h04, 5'd0, 5'd0, 32'hFFFF_FFE3, 32'h0000_0001, "R4 sllv upper ignored");
      send(6'h04, 5'd0, 5'd1, 32'h0000_0003, 32'h0000_0001, "R4 sllv sa set");
      send(6'h06, 5'd0, 5'd0, 32'hABCD_EF04, 32'h8000_0000, "R4 srlv");
      send(6'h06, 5'd0, 5'd1, 32'h5555_5524, 32'h1234_5678, "R4 rotrv");
      send(6'h06, 5'd0, 5'd2, 32'h0000_0004, 32'h1234_5678, "R4 srlv sa reserved");
      send(6'h07, 5'd0, 5'd0, 32'hFFFF_FFFF, 32'h8000_0000, "R4 srav 31");
      send(6'h07, 5'd0, 5'd8, 32'h0000_0001, 32'h8000_0000, "R4 srav sa set");
      // R5 zero amount
      send(6'h02, 5'd1, 5'd0, 32'h0, 32'hDEAD_BEEF, "R5 rotr 0");
      send(6'h06, 5'd0, 5'd1, 32'hFFFF_FFE0, 32'hCAFE_F00D, "R5 rotrv 0");
      send(6'h07, 5'd0, 5'd0, 32'h0000_0020, 32'h8765_4321, "R5 srav 0");
      send(6'h00, 5'd0, 5'd0, 32'h0, 32'h1357_9BDF, "R5 sll 0");
      // R6 / R7 non-shift codes
      send(6'h01, 5'd0, 5'd0, 32'h0, 32'hFFFF_FFFF, "R6 funct 01");
      send(6'h05, 5'd0, 5'd0, 32'h3, 32'hFFFF_FFFF, "R6 funct 05");
      send(6'h20, 5'd0, 5'd0, 32'h3, 32'hFFFF_FFFF, "R7 funct 20");
      idle(3);

      // mixed legal traffic
      for (int n = 0; n < 300; n++) begin
         logic [5:0] f;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[2:0])
            3'd0: f = 6'h00; 3'd1: f = 6'h02; 3'd2: f = 6'h03;
            3'd3: f = 6'h04; 3'd4: f = 6'h06; default: f = 6'h07;
         endcase
         send(f, (f == 6'h02) ? {4'h0, lfsr[3]} : 5'd0,
              (f == 6'h06) ? {4'h0, lfsr[3]} : ((f[2]) ? 5'd0 : lfsr[8:4]),
              {lfsr[15:0], lfsr[31:16]} ^ 32'h9E37_79B9, lfsr, "R4 mixed traffic");
         if (lfsr[9]) idle(1);
      end
      idle(3);
      check(q_res.size() == 0, "R8 all results seen", q_res.size(), 32'h0);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule